// File: doc/BRIEF.md
# LCD Horizontal Line Timing Generator

This block produces the horizontal timing of one display line at a time for an LCD panel interface. It advances only on cycles where an internal pixel-rate enable is high. Each such cycle is called a *tick*, meaning a rising clock edge with both `en` and `pix_en` high. Every tick emits one *slot*. The slots run in a fixed loop: a line clock (horizontal sync) pulse, a back porch of dummy slots, the active pixels, a front porch of dummy slots, and then the line clock pulse of the next line.

The outputs are:
- the line clock;
- a data enable that covers exactly the active pixels;
- a one-cycle request pulse at the start of each active pixel, which tells the pixel source to present the next pixel;
- a pixel clock output that toggles once per tick.

In passive display mode the pixel clock is frozen outside the active pixels. In active display mode it runs on every tick.

Four programmable fields set the segment lengths. Each field encodes the number of slots minus one. The fields are captured into line-local copies at each line boundary, so software may rewrite them at any time without breaking the current line. Vertical timing, pixel fetch and colour formatting belong to other blocks.

The state machine has four states:
- `ST_SYNC`: line clock high.
- `ST_BACK`: back porch.
- `ST_ACT`: active pixels.
- `ST_FRONT`: front porch.

There are four transitions, and each one is taken on a tick whose segment count has reached its captured limit:
- `SYNC_DONE`: from `ST_SYNC` to `ST_BACK`.
- `BACK_DONE`: from `ST_BACK` to `ST_ACT`.
- `PIX_DONE`: from `ST_ACT` to `ST_FRONT`.
- `LINE_DONE`: from `ST_FRONT` to `ST_SYNC`. This transition also reloads the captured fields.

Clearing `en` forces the machine back to `ST_SYNC` with its count at zero.

Top module: `lcd_hline_gen`

## Requirements
- R1: After reset, and on every clock edge where `en` is low, all four outputs are 0. The generator returns to the start of a line with its count cleared, and it captures the current field values. The first tick after `en` rises emits the first sync slot.
- R2: Slots follow the order sync, back porch, active, front porch, and then sync again, without end. `line_clk` and `data_en` are never high together.
- R3: The sync segment lasts `cfg_sync_w`+1 slots, and `line_clk` is 1 in each of them.
- R4: The back porch starts in the slot right after `line_clk` falls. It lasts `cfg_back`+1 slots, during which `line_clk`, `data_en` and `pix_req` are 0.
- R5: The active segment lasts `cfg_pixels`+1 slots, and `data_en` is 1 in exactly those slots.
- R6: `pix_req` is 1 for exactly one clock cycle at the start of each active slot, namely the cycle after the tick. It is 0 in every other cycle.
- R7: The front porch lasts `cfg_front`+1 slots with all of `line_clk`, `data_en` and `pix_req` at 0. The next sync slot follows right after it.
- R8: With `passive_mode`=1, `pix_clk_out` inverts on ticks that emit an active slot. It holds its value on ticks that emit sync, back porch or front porch slots.
- R9: With `passive_mode`=0, `pix_clk_out` inverts on every tick.
- R10: On a clock edge with `en`=1 and `pix_en`=0, `line_clk`, `data_en` and `pix_clk_out` hold their values, and `pix_req` is 0.
- R11: The field values are captured on the tick that ends the front porch, including a value written in that same cycle. A write made at any other point of a line changes only the following line.
- R12: Field value 0 gives one slot and value 255 gives 256 slots, for both the porch fields and the sync field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Global enable; low holds the generator idle |
| pix_en | input | 1 | Pixel-rate enable; one slot per tick |
| passive_mode | input | 1 | 1 = passive panel (pixel clock gated), 0 = active panel |
| cfg_sync_w | input | PORCH_W | Line clock width minus one |
| cfg_back | input | PORCH_W | Back porch slots minus one |
| cfg_pixels | input | PPL_W | Active pixels per line minus one |
| cfg_front | input | PORCH_W | Front porch slots minus one |
| line_clk | output | 1 | Horizontal sync pulse |
| data_en | output | 1 | High during active pixel slots |
| pix_req | output | 1 | One-cycle request at the start of each active slot |
| pix_clk_out | output | 1 | Pixel clock to the panel, gated in passive mode |

## Verification
Two events can fall in the same cycle: the front porch ending (the `LINE_DONE` transition) and a software write to the timing fields. The write must shape the coming line, while any write made even one tick earlier must not disturb the line still in progress. The bench provokes this with directed writes placed mid-line and with random field changes at random cycles, under random `pix_en` gaps. A bench model reloads its own field copies only at the line boundary, and the output in every slot is compared against that model. A drop of `en` on a tick cycle is a second collision, and it must win over the advance.

// File: rtl/lcd_hline_pkg.sv
package lcd_hline_pkg;

    // one state per line segment; the numbering is only for readability
    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_BACK  = 2'd1,
        ST_ACT   = 2'd2,
        ST_FRONT = 2'd3
    } hl_state_e;

    function automatic int unsigned hl_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcd_hline_shadow.sv
// Line-local copy of the timing fields, refreshed on a load strobe.
module lcd_hline_shadow #(
    parameter int unsigned PORCH_W = 8,
    parameter int unsigned PPL_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PORCH_W-1:0] in_sync_w,
    input  logic [PORCH_W-1:0] in_back,
    input  logic [PPL_W-1:0]   in_pixels,
    input  logic [PORCH_W-1:0] in_front,
    output logic [PORCH_W-1:0] q_sync_w,
    output logic [PORCH_W-1:0] q_back,
    output logic [PPL_W-1:0]   q_pixels,
    output logic [PORCH_W-1:0] q_front
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_sync_w <= '0;
            q_back   <= '0;
            q_pixels <= '0;
            q_front  <= '0;
        end else if (load) begin
            q_sync_w <= in_sync_w;
            q_back   <= in_back;
            q_pixels <= in_pixels;
            q_front  <= in_front;
        end
    end

endmodule

// File: rtl/lcd_hline_seg_cnt.sv
// Segment counter: counts steps up to a limit, flags the last step.
module lcd_hline_seg_cnt #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    assign last = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_hline_pclk.sv
// Toggling pixel clock output with a gate; cleared while idle.
module lcd_hline_pclk (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic gate_open,
    output logic pclk
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pclk <= 1'b0;
        end else if (clr) begin
            pclk <= 1'b0;
        end else if (step && gate_open) begin
            pclk <= ~pclk;
        end
    end

endmodule

// File: rtl/lcd_hline_gen.sv
module lcd_hline_gen
    import lcd_hline_pkg::*;
#(
    parameter int unsigned PORCH_W = 8,
    parameter int unsigned PPL_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               pix_en,
    input  logic               passive_mode,
    input  logic [PORCH_W-1:0] cfg_sync_w,
    input  logic [PORCH_W-1:0] cfg_back,
    input  logic [PPL_W-1:0]   cfg_pixels,
    input  logic [PORCH_W-1:0] cfg_front,
    output logic               line_clk,
    output logic               data_en,
    output logic               pix_req,
    output logic               pix_clk_out
);

    localparam int unsigned CNT_W = hl_max(PORCH_W, PPL_W);

    hl_state_e        state_q;
    hl_state_e        state_nxt;
    logic             tick;
    logic             seg_last;
    logic [CNT_W-1:0] seg_limit;
    logic             line_done;
    logic             st_active;

    logic [PORCH_W-1:0] sh_sync_w;
    logic [PORCH_W-1:0] sh_back;
    logic [PPL_W-1:0]   sh_pixels;
    logic [PORCH_W-1:0] sh_front;

    assign tick      = en & pix_en;
    assign st_active = (state_q == ST_ACT);
    assign line_done = tick & (state_q == ST_FRONT) & seg_last;

    // fields captured while idle and at each line boundary
    lcd_hline_shadow #(
        .PORCH_W (PORCH_W),
        .PPL_W   (PPL_W)
    ) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (~en | line_done),
        .in_sync_w (cfg_sync_w),
        .in_back   (cfg_back),
        .in_pixels (cfg_pixels),
        .in_front  (cfg_front),
        .q_sync_w  (sh_sync_w),
        .q_back    (sh_back),
        .q_pixels  (sh_pixels),
        .q_front   (sh_front)
    );

    // limit of the segment being emitted
    always_comb begin
        unique case (state_q)
            ST_SYNC:  seg_limit = CNT_W'(sh_sync_w);
            ST_BACK:  seg_limit = CNT_W'(sh_back);
            ST_ACT:   seg_limit = CNT_W'(sh_pixels);
            ST_FRONT: seg_limit = CNT_W'(sh_front);
        endcase
    end

    lcd_hline_seg_cnt #(
        .CNT_W (CNT_W)
    ) u_seg_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (~en),
        .step  (tick),
        .limit (seg_limit),
        .last  (seg_last)
    );

    // transitions: SYNC_DONE, BACK_DONE, PIX_DONE, LINE_DONE
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_SYNC:  if (seg_last) state_nxt = ST_BACK;
            ST_BACK:  if (seg_last) state_nxt = ST_ACT;
            ST_ACT:   if (seg_last) state_nxt = ST_FRONT;
            ST_FRONT: if (seg_last) state_nxt = ST_SYNC;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SYNC;
        end else if (!en) begin
            state_q <= ST_SYNC;
        end else if (pix_en) begin
            state_q <= state_nxt;
        end
    end

    // outputs: each tick emits the slot of the current state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_clk <= 1'b0;
            data_en  <= 1'b0;
            pix_req  <= 1'b0;
        end else if (!en) begin
            line_clk <= 1'b0;
            data_en  <= 1'b0;
            pix_req  <= 1'b0;
        end else begin
            pix_req <= 1'b0;
            if (pix_en) begin
                line_clk <= (state_q == ST_SYNC);
                data_en  <= st_active;
                pix_req  <= st_active;
            end
        end
    end

    lcd_hline_pclk u_pclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (~en),
        .step      (tick),
        .gate_open (~passive_mode | st_active),
        .pclk      (pix_clk_out)
    );

endmodule

// File: rtl/lcd_hline_gen_chk.sv
module lcd_hline_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic pix_en,
    input logic passive_mode,
    input logic st_active,
    input logic line_clk,
    input logic data_en,
    input logic pix_req,
    input logic pix_clk_out
);

    // R1
    a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!line_clk && !data_en && !pix_req && !pix_clk_out));

    // R2
    a_r2_sync_data_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({line_clk, data_en}));

    // R6
    a_r6_req_within_data: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |-> data_en);

    // R10
    a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !pix_en) |=> ($stable(line_clk) && $stable(data_en) && $stable(pix_clk_out) && !pix_req));

    // R8
    a_r8_passive_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pix_en && passive_mode && !st_active) |=> $stable(pix_clk_out));

    // R9
    a_r9_active_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pix_en && !passive_mode) |=> (pix_clk_out != $past(pix_clk_out)));

endmodule

bind lcd_hline_gen lcd_hline_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .pix_en       (pix_en),
    .passive_mode (passive_mode),
    .st_active    (st_active),
    .line_clk     (line_clk),
    .data_en      (data_en),
    .pix_req      (pix_req),
    .pix_clk_out  (pix_clk_out)
);

// File: tb/lcd_hline_gen_bench.sv
module lcd_hline_gen_bench;

    localparam int PW = 8;
    localparam int LW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic pix_en = 1'b0;
    logic passive = 1'b0;
    logic [PW-1:0] hsw = '0;
    logic [PW-1:0] hbp = '0;
    logic [LW-1:0] ppl = '0;
    logic [PW-1:0] hfp = '0;
    logic line_clk, data_en, pix_req, pclk;

    always #2 clk = ~clk;

    lcd_hline_gen #(.PORCH_W(PW), .PPL_W(LW)) u_lcd_hline_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .pix_en       (pix_en),
        .passive_mode (passive),
        .cfg_sync_w   (hsw),
        .cfg_back     (hbp),
        .cfg_pixels   (ppl),
        .cfg_front    (hfp),
        .line_clk     (line_clk),
        .data_en      (data_en),
        .pix_req      (pix_req),
        .pix_clk_out  (pclk)
    );

    int checks = 0;
    int errors = 0;
    string tag_ovr = "";

    // line model: phase 0 sync, 1 back, 2 active, 3 front
    int m_ph = 0, m_cnt = 0;
    int s_hsw = 0, s_hbp = 0, s_ppl = 0, s_hfp = 0;
    logic e_lc = 0, e_de = 0, e_req = 0, e_pc = 0;

    function automatic int lim_of(input int ph);
        case (ph)
            0:       return s_hsw;
            1:       return s_hbp;
            2:       return s_ppl;
            default: return s_hfp;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic load_model();
        s_hsw = hsw; s_hbp = hbp; s_ppl = ppl; s_hfp = hfp;
    endtask

    task automatic cycle(input bit pe);
        string t;
        string tq;
        string tc;
        pix_en = pe;
        if (!en) begin
            m_ph = 0; m_cnt = 0; load_model();
            e_lc = 0; e_de = 0; e_req = 0; e_pc = 0;
            t = "R1";
        end else if (pe) begin
            case (m_ph)
                0:       t = "R3";
                1:       t = "R4";
                2:       t = "R5";
                default: t = "R7";
            endcase
            e_lc  = (m_ph == 0);
            e_de  = (m_ph == 2);
            e_req = (m_ph == 2);
            if (m_ph == 2 || !passive) e_pc = ~e_pc;
            if (m_cnt == lim_of(m_ph)) begin
                if (m_ph == 3) load_model(); // R11 line boundary capture
                m_cnt = 0;
                m_ph = (m_ph + 1) % 4;
            end else begin
                m_cnt++;
            end
        end else begin
            e_req = 0;
            t = "R10";
        end
        if (tag_ovr != "") t = tag_ovr;
        tq = (en && tag_ovr == "") ? "R6" : t;
        tc = (en && pe && tag_ovr == "") ? (passive ? "R8" : "R9") : t;
        @(posedge clk);
        @(negedge clk);
        chk(t,  "line_clk",    line_clk, e_lc);
        chk(t,  "data_en",     data_en,  e_de);
        chk(tq, "pix_req",     pix_req,  e_req);
        chk(tc, "pix_clk_out", pclk,     e_pc);
    endtask

    task automatic run(input int n, input int pe_pct);
        for (int i = 0; i < n; i++) cycle(($urandom % 100) < pe_pct);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "line_clk",    line_clk, 1'b0);
        chk("R1", "data_en",     data_en,  1'b0);
        chk("R1", "pix_req",     pix_req,  1'b0);
        chk("R1", "pix_clk_out", pclk,     1'b0);
        rst_n = 1'b1;

        // R2: plain ordered lines, active mode, full rate
        hsw = 1; hbp = 2; ppl = 3; hfp = 1; passive = 0;
        tag_ovr = "R2";
        run(3, 100);
        en = 1;
        run(30, 100);

        // R12: minimum fields, passive mode, with gaps
        tag_ovr = "R12";
        hsw = 0; hbp = 0; ppl = 0; hfp = 0; passive = 1;
        run(40, 60);
        // R12: maximum porch and sync fields
        hsw = 255; hbp = 255; hfp = 255; ppl = 4;
        run(1600, 100);

        // R11: mid-line writes only reach the next line
        tag_ovr = "R11";
        en = 0; hsw = 0; hbp = 1; ppl = 2; hfp = 1; passive = 0;
        run(2, 100);
        en = 1;
        run(4, 100);
        hbp = 5; ppl = 9; hfp = 3;
        run(40, 100);

        // R1: enable dropped in mid-line, then restarted
        tag_ovr = "R1";
        run(5, 100);
        en = 0;
        run(3, 100);
        en = 1;
        run(20, 100);

        // random: field changes at random cycles, random gaps and modes
        tag_ovr = "";
        for (int blk = 0; blk < 60; blk++) begin
            hsw = PW'($urandom % 8);
            hbp = PW'($urandom % 12);
            ppl = LW'($urandom % 24);
            hfp = PW'($urandom % 12);
            passive = 1'($urandom % 2);
            if (($urandom % 10) == 0) begin
                en = 0;
                run(2, 50);
                en = 1;
            end
            run(150, 30 + ($urandom % 70));
        end

        summary();
        $finish;
    end

endmodule